// File: doc/BRIEF.md
# Instruction Fetch Front End with Redirect Draining

This block is the front end of a simple in-order core. It owns the program counter and issues one read per cycle to an instruction memory that works in split transactions. The memory takes a request, later shows the response at the head of its return stream, and lets it go when the block strobes a dequeue. Responses come back in request order but after a variable delay. The block keeps only a count of outstanding reads, one token per request. That count caps how many reads may be in flight at once.

The head response is decoded against a small register file. When the execute side reports no stall, the decoded record is handed over and the response is released. The record holds the opcode, the destination index and two operand values. Write-backs from execute update the register file, and a decode in the same cycle sees the new value at once.

A redirect loads a new program counter. The memory is not flushed. If reads are still outstanding, the block enters a drain mode. In drain mode it issues no requests and performs no decode, and it releases and discards each stale response as it arrives. When no tokens remain, drain mode ends and fetching restarts at the redirect target.

Top module: `fetch_front`

## Requirements
- R1: After reset the program counter is zero, no reads are outstanding and the unit is not draining. The first request therefore carries address 0 and no decode is offered.
- R2: Each accepted request (memReqValid and memReqReady both high) carries the current PC, and the next request carries that address plus one, modulo 2^ADDR_W.
- R3: Outstanding reads never exceed TOKEN_DEPTH. memReqValid is low whenever TOKEN_DEPTH reads are outstanding.
- R4: decValid is high exactly when these all hold: a response is present, at least one read is outstanding, the unit is not draining, no redirect is presented, and exStall is low. memRspDeq is high with it.
- R5: The instruction word is {opcode, dst, srcA, srcB} from the most significant bits down, with OP_W bits for the opcode and log2(NUM_REGS) bits for each index. decOp and decDst are those fields. decValA and decValB are the register contents at srcA and srcB.
- R6: A write-back with wbValid high stores wbData in register wbDst at the clock edge. An operand read in the same cycle that names wbDst returns wbData.
- R7: A redirect presented while reads are outstanding starts drain mode. During drain, memReqValid and decValid stay low. Each cycle that a response is present and a read is outstanding, memRspDeq releases and drops it.
- R8: A cycle that presents a redirect issues no request and no decode. If no reads are outstanding after that cycle, the next cycle requests the redirect target.
- R9: Drain mode ends in the cycle after one in which no reads are outstanding. The first request that follows carries the most recent redirect target.
- R10: A redirect during drain mode reloads the PC and draining continues. A redirect and a write-back in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memReqValid | output | 1 | Read request offered |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Address of the request (current PC) |
| memRspValid | input | 1 | A response is at the head of the return stream |
| memRspData | input | OP_W+3*log2(NUM_REGS) | Head instruction word |
| memRspDeq | output | 1 | Release the head response |
| exStall | input | 1 | Execute side cannot take the head instruction |
| decValid | output | 1 | Decoded record handed over this cycle |
| decOp | output | OP_W | Opcode field |
| decDst | output | log2(NUM_REGS) | Destination index |
| decValA | output | DATA_W | Value of first source register |
| decValB | output | DATA_W | Value of second source register |
| redirValid | input | 1 | Redirect request |
| redirPc | input | ADDR_W | Redirect target |
| wbValid | input | 1 | Register write-back |
| wbDst | input | log2(NUM_REGS) | Write-back register index |
| wbData | input | DATA_W | Write-back value |

## Verification
The bench builds the block with ADDR_W of 8, DATA_W of 8, sixteen registers and TOKEN_DEPTH of 3. This makes the full-queue stall frequent, and the PC wraps through all 256 addresses several times over a run of a few thousand cycles. The memory model has latencies of one to four cycles and request-ready gaps. Together these make every path reachable: redirects that arrive with zero, one, two or three reads in flight, redirects during drain, and same-index write-back bypass. A window with requests held off leaves the token count at zero for a redirect.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  // Strobes from control to datapath, one per cycle.
  typedef struct packed {
    logic fetch;     // request accepted, advance PC
    logic decode;    // head decoded and handed over
    logic drop;      // head discarded during drain
    logic redirect;  // load PC from redirect target
  } ctrlStrobe_t;
endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
#(
  parameter int TOKEN_DEPTH = 4,
  parameter int CNT_W = $clog2(TOKEN_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             memReqReady,
  input  logic             memRspValid,
  input  logic             exStall,
  input  logic             redirValid,
  output logic             reqOffer,
  output ctrlStrobe_t      strobe,
  output logic             draining,
  output logic [CNT_W-1:0] tokCount
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TOKEN_DEPTH);

  logic             haveTok;
  logic             popTok;
  logic [CNT_W-1:0] cntNext;
  logic             drainNext;

  assign haveTok  = tokCount != '0;
  assign reqOffer = !draining && (tokCount != FULL) && !redirValid;

  always_comb begin
    strobe.fetch    = reqOffer && memReqReady;
    strobe.decode   = !draining && !redirValid && memRspValid && haveTok && !exStall;
    strobe.drop     = draining && memRspValid && haveTok;
    strobe.redirect = redirValid;
  end

  assign popTok  = strobe.decode || strobe.drop;
  assign cntNext = tokCount + CNT_W'(strobe.fetch) - CNT_W'(popTok);

  always_comb begin
    if (redirValid) drainNext = cntNext != '0;
    else            drainNext = draining && haveTok;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tokCount <= '0;
      draining <= 1'b0;
    end else begin
      tokCount <= cntNext;
      draining <= drainNext;
    end
  end
endmodule

// File: rtl/fetch_dp.sv
module fetch_dp
  import fetch_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  parameter int OP_W     = 4,
  parameter int REG_W    = $clog2(NUM_REGS),
  parameter int INSTR_W  = OP_W + 3 * REG_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [ADDR_W-1:0]  redirPc,
  input  logic [INSTR_W-1:0] memRspData,
  input  logic               wbValid,
  input  logic [REG_W-1:0]   wbDst,
  input  logic [DATA_W-1:0]  wbData,
  output logic [ADDR_W-1:0]  pc,
  output logic [OP_W-1:0]    decOp,
  output logic [REG_W-1:0]   decDst,
  output logic [DATA_W-1:0]  decValA,
  output logic [DATA_W-1:0]  decValB
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [REG_W-1:0] srcA, srcB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pc <= '0;
    else if (strobe.redirect) pc <= redirPc;
    else if (strobe.fetch)    pc <= pc + ADDR_W'(1);
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                regs[g] <= '0;
      else if (wbValid && wbDst == REG_W'(g))   regs[g] <= wbData;
    end
  end

  assign decOp  = memRspData[INSTR_W-1 -: OP_W];
  assign decDst = memRspData[3*REG_W-1 -: REG_W];
  assign srcA   = memRspData[2*REG_W-1 -: REG_W];
  assign srcB   = memRspData[REG_W-1:0];

  // Write-back bypass into the operand read.
  always_comb begin
    decValA = (wbValid && wbDst == srcA) ? wbData : regs[srcA];
    decValB = (wbValid && wbDst == srcB) ? wbData : regs[srcB];
  end
endmodule

// File: rtl/fetch_front.sv
module fetch_front
  import fetch_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int NUM_REGS    = 16,
  parameter int OP_W        = 4,
  parameter int TOKEN_DEPTH = 4,
  parameter int REG_W       = $clog2(NUM_REGS),
  parameter int INSTR_W     = OP_W + 3 * REG_W
) (
  input  logic               clk,
  input  logic               rstN,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [ADDR_W-1:0]  memReqAddr,
  input  logic               memRspValid,
  input  logic [INSTR_W-1:0] memRspData,
  output logic               memRspDeq,
  input  logic               exStall,
  output logic               decValid,
  output logic [OP_W-1:0]    decOp,
  output logic [REG_W-1:0]   decDst,
  output logic [DATA_W-1:0]  decValA,
  output logic [DATA_W-1:0]  decValB,
  input  logic               redirValid,
  input  logic [ADDR_W-1:0]  redirPc,
  input  logic               wbValid,
  input  logic [REG_W-1:0]   wbDst,
  input  logic [DATA_W-1:0]  wbData
);
  localparam int CNT_W = $clog2(TOKEN_DEPTH + 1);

  ctrlStrobe_t      strobe;
  logic             draining;
  logic [CNT_W-1:0] tokCount;

  fetch_ctrl #(.TOKEN_DEPTH(TOKEN_DEPTH), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .exStall(exStall), .redirValid(redirValid), .reqOffer(memReqValid),
    .strobe(strobe), .draining(draining), .tokCount(tokCount)
  );

  fetch_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .OP_W(OP_W),
             .REG_W(REG_W), .INSTR_W(INSTR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .redirPc(redirPc),
    .memRspData(memRspData), .wbValid(wbValid), .wbDst(wbDst), .wbData(wbData),
    .pc(memReqAddr), .decOp(decOp), .decDst(decDst), .decValA(decValA), .decValB(decValB)
  );

  assign decValid  = strobe.decode;
  assign memRspDeq = strobe.decode || strobe.drop;
endmodule

// File: rtl/fetch_front_chk.sv
module fetch_front_chk #(
  parameter int ADDR_W      = 16,
  parameter int TOKEN_DEPTH = 4,
  parameter int CNT_W       = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              memRspDeq,
  input logic              decValid,
  input logic              redirValid,
  input logic [ADDR_W-1:0] redirPc,
  input logic              draining,
  input logic [CNT_W-1:0]  tokCount
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    tokCount <= CNT_W'(TOKEN_DEPTH));

  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    tokCount == CNT_W'(TOKEN_DEPTH) |-> !memReqValid);

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady |=> memReqAddr == $past(memReqAddr) + ADDR_W'(1));

  p_deq_with_decode_r4: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> memRspDeq && memRspValid && !redirValid);

  p_drain_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    draining |-> !memReqValid && !decValid);

  p_redir_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |=> memReqAddr == $past(redirPc));

  p_drain_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    draining && tokCount == '0 && !redirValid |=> !draining);

  p_redir_keeps_drain_r10: assert property (@(posedge clk) disable iff (!rstN)
    draining && redirValid && tokCount > CNT_W'(1) |=> draining);
endmodule

bind fetch_front fetch_front_chk #(.ADDR_W(ADDR_W), .TOKEN_DEPTH(TOKEN_DEPTH), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspDeq(memRspDeq),
  .decValid(decValid), .redirValid(redirValid), .redirPc(redirPc),
  .draining(draining), .tokCount(tokCount)
);

// File: tb/sim_fetch_front.sv
module sim_fetch_front;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 8, NR = 16, OW = 4, DEPTH = 3;
  localparam int RW = 4, IW = 16, NCYC = 3000;

  logic clk = 1'b0, rstN = 1'b0;
  logic memReqValid, memReqReady = 1'b0, memRspValid = 1'b0, memRspDeq;
  logic [AW-1:0] memReqAddr, redirPc = '0;
  logic [IW-1:0] memRspData = '0;
  logic exStall = 1'b0, decValid, redirValid = 1'b0, wbValid = 1'b0;
  logic [OW-1:0] decOp;
  logic [RW-1:0] decDst, wbDst = '0;
  logic [DW-1:0] decValA, decValB, wbData = '0;

  fetch_front #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR), .OP_W(OW), .TOKEN_DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .memRspDeq(memRspDeq), .exStall(exStall), .decValid(decValid), .decOp(decOp),
    .decDst(decDst), .decValA(decValA), .decValB(decValB), .redirValid(redirValid),
    .redirPc(redirPc), .wbValid(wbValid), .wbDst(wbDst), .wbData(wbData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [IW-1:0] instrAt(input logic [AW-1:0] a);
    logic [15:0] x;
    x = (16'(a) * 16'd40503) ^ 16'h5A3C;
    return x;
  endfunction

  // Responder and reference model state
  logic [AW-1:0] qAddr [8];
  int qRdy [8];
  int qHead = 0, qCnt = 0;
  logic [DW-1:0] regsM [NR];
  logic [AW-1:0] expPc = '0;
  bit expDrain = 1'b0, lastRedirEmpty = 1'b0, leftDrain = 1'b0, redirInDrain = 1'b0;
  int covEmptyRedir = 0, covDrainRedir = 0, covBypass = 0, covDrops = 0, covFull = 0;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) regsM[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    memReqReady = 1'b0;
    #1;
    // R1: reset state
    chk(memReqValid == 1'b1, "R1", memReqValid, 1);
    chk(memReqAddr == 8'd0, "R1", memReqAddr, 0);
    chk(decValid == 1'b0, "R1", decValid, 0);
    chk(memRspDeq == 1'b0, "R1", memRspDeq, 0);

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      bit rspVis, expReq, expDec, expDeq, bypA, bypB;
      logic [IW-1:0] ins;
      logic [DW-1:0] eA, eB;
      int cntNext;
      string tag;
      @(negedge clk);
      memReqReady = !((cyc % 11) == 4) && !(cyc >= 1000 && cyc < 1040);
      exStall     = ((cyc % 7) == 2) || ((cyc % 17) == 5);
      redirValid  = ((cyc % 41) == 20) || ((cyc % 41) == 22) || (cyc == 1035);
      redirPc     = AW'(cyc * 29 + 7);
      wbValid     = (cyc % 3) != 0;
      wbDst       = RW'(cyc * 5);
      wbData      = DW'(cyc * 13);
      rspVis      = (qCnt > 0) && (cyc >= qRdy[qHead]);
      memRspValid = rspVis;
      memRspData  = rspVis ? instrAt(qAddr[qHead]) : '0;
      #1;
      expReq = !expDrain && (qCnt < DEPTH) && !redirValid;
      expDec = !expDrain && !redirValid && rspVis && !exStall;
      expDeq = expDec || (expDrain && rspVis);
      if (qCnt == DEPTH) covFull++;
      tag = expDrain ? (redirInDrain ? "R10" : "R7") : (qCnt == DEPTH ? "R3" : (redirValid ? "R8" : "R2"));
      chk(memReqValid == expReq, tag, memReqValid, expReq);
      if (memReqValid && expReq) begin
        tag = lastRedirEmpty ? "R8" : (leftDrain ? "R9" : "R2");
        chk(memReqAddr == expPc, tag, memReqAddr, expPc);
        lastRedirEmpty = 1'b0; leftDrain = 1'b0;
      end
      chk(decValid == expDec, expDrain ? "R7" : "R4", decValid, expDec);
      chk(memRspDeq == expDeq, expDrain ? "R7" : "R4", memRspDeq, expDeq);
      if (expDrain && rspVis) covDrops++;
      if (expDec && decValid) begin
        ins = instrAt(qAddr[qHead]);
        bypA = wbValid && wbDst == ins[7:4];
        bypB = wbValid && wbDst == ins[3:0];
        eA = bypA ? wbData : regsM[ins[7:4]];
        eB = bypB ? wbData : regsM[ins[3:0]];
        if (bypA || bypB) covBypass++;
        chk(decOp == ins[15:12], "R5", decOp, ins[15:12]);
        chk(decDst == ins[11:8], "R5", decDst, ins[11:8]);
        chk(decValA == eA, bypA ? "R6" : "R5", decValA, eA);
        chk(decValB == eB, bypB ? "R6" : "R5", decValB, eB);
      end
      // Model the clock edge
      if (expDeq && qCnt > 0) begin qHead = (qHead + 1) % 8; qCnt--; end
      if (expReq && memReqReady) begin
        qAddr[(qHead + qCnt) % 8] = expPc;
        qRdy[(qHead + qCnt) % 8]  = cyc + 1 + (cyc % 4);
        qCnt++;
        expPc = expPc + 1'b1;
      end
      cntNext = qCnt;
      if (wbValid) regsM[wbDst] = wbData;  // R10: write-back lands alongside a redirect
      if (redirValid) begin
        expPc = redirPc;
        if (expDrain) covDrainRedir++;
        redirInDrain = expDrain;
        lastRedirEmpty = (cntNext == 0);
        if (cntNext == 0) covEmptyRedir++;
        expDrain = (cntNext != 0);
      end else if (expDrain) begin
        if (!rspVis && (qCnt == 0)) begin expDrain = 1'b0; leftDrain = 1'b1; end
        else if (qCnt == 0 && !expDeq) begin expDrain = 1'b0; leftDrain = 1'b1; end
      end
    end

    // Coverage of corner cases named by the requirements
    chk(covFull > 0, "R3", covFull, 1);
    chk(covDrops > 0, "R7", covDrops, 1);
    chk(covEmptyRedir > 0, "R8", covEmptyRedir, 1);
    chk(covDrainRedir > 0, "R10", covDrainRedir, 1);
    chk(covBypass > 0, "R6", covBypass, 1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule